// File: doc/BRIEF.md
# Three-Requester Arbiter with Starvation Guard

This block shares one resource among three requesters, one at a time. Each requester raises its own request line and receives its own grant line. A grant stays in place for as long as the owning request stays high. When that request falls, the arbiter goes back to its idle state for one cycle and then makes a fresh decision. The grant outputs come straight from a decode of the state register, so this is a Moore machine. A grant changes only on a clock edge, and only as a result of the requests sampled at that edge.

The decision order is fixed: requester 1 first, then requester 2, then requester 3. A plain fixed order would let requesters 1 and 2 keep requester 3 out forever by taking turns. To stop that, the arbiter keeps two "served while 3 waits" marks, one for requester 1 and one for requester 2. While request 3 is high, a requester whose mark is set cannot win a decision. Requester 3 is therefore granted after at most one grant each to requesters 1 and 2. Both marks are cleared when requester 3 is granted, when request 3 falls, and on reset.

Top module: `arb3_starve_guard`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, the arbiter goes idle and all grants are 0 after that edge, whatever the requests are. Both marks are cleared, so the first decision after reset follows the plain fixed order.
- R2: `gnt` never has more than one bit set. Bit 0 grants requester 1 (request bit 0), bit 1 grants requester 2, and bit 2 grants requester 3.
- R3: When the arbiter is idle and all requests are 0, it stays idle and the grants remain 0.
- R4: When deciding from idle with request 3 low, or with no mark set, the grant goes to the lowest-numbered active request. Requester 3 wins only when it is the only requester. The grant appears one clock after the edge at which the requests were sampled.
- R5: A granted requester keeps its grant while its request stays 1, even if other requests are active.
- R6: When the granted requester's request is 0 at an edge, all grants are 0 after that edge, for one cycle, before any new grant appears.
- R7: While request 3 stays high, requesters 1 and 2 are each granted at most once. A requester already served in this waiting period is skipped in favour of the next eligible one.
- R8: Once both requester 1 and requester 2 have been served while request 3 is waiting, the next decision grants requester 3, even with requests 1 and 2 high.
- R9: If request 3 falls before it is granted, both marks clear. A later wait by requester 3 starts fresh, and requester 1 can again win its first decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 3 | Request lines; bit 0 is requester 1 (highest priority) and bit 2 is requester 3 |
| gnt | output | 3 | Grant lines, at most one bit high, same bit order as `req` |

## Verification
Every result of this arbiter is due exactly one rising edge after the requests that cause it. A new grant, an idle after a release, and the reset state each appear after the first edge at which the inputs are sampled. Going from one grant to the next therefore takes two edges, with one idle cycle between them.

The bench changes the request and reset inputs at the falling edge. At the same time it queues the grant pattern expected after the following rising edge. A separate monitor takes one queued item a quarter period after each rising edge and compares it with `gnt`, so each check lines up with the single register stage between input and output. The starvation sequences keep requests 1 and 2 high, dropping each only to end its grant. They confirm that requester 3 is granted after no more than two other grants.

// File: rtl/arb3_pkg.sv
// Package: shared sizes and state encoding for the three-requester arbiter.
// Assumes exactly one idle state plus one grant state per requester, and that
// grant state k+1 belongs to requester index k.
package arb3_pkg;
    localparam int NREQ = 3;                 // number of requesters
    localparam int NHI  = NREQ - 1;          // requesters that can be passed over for the last one
    localparam int SW   = $clog2(NREQ + 1);  // state width

    typedef enum logic [SW-1:0] {
        ST_IDLE = 2'd0,
        ST_G1   = 2'd1,
        ST_G2   = 2'd2,
        ST_G3   = 2'd3
    } arb_state_e;

    // Map a requester index (0-based) to the grant state that serves it.
    function automatic arb_state_e serve_state(input int idx);
        return arb_state_e'(SW'(idx + 1));
    endfunction
endpackage

// File: rtl/arb3_pick.sv
// Module: next-state selection for the arbiter.
// Holds a grant while its request stays high and returns to idle when it drops.
// From idle it picks the lowest-numbered eligible requester. A requester is not
// eligible if it has already been served while the last requester waits.
// Assumes the mark vector comes from arb3_fair_flags and is registered.
module arb3_pick
    import arb3_pkg::*;
(
    input  arb_state_e          cur_st,
    input  logic [NREQ-1:0]     req,
    input  logic [NHI-1:0]      served,
    output arb_state_e          nxt_st
);
    logic [NHI-1:0] elig;
    logic           last_wait;

    assign last_wait = req[NREQ-1];

    // Eligibility of each higher-priority requester under the fairness rule.
    genvar gi;
    generate
        for (gi = 0; gi < NHI; gi++) begin : g_elig
            assign elig[gi] = req[gi] & ~(last_wait & served[gi]);
        end
    endgenerate

    // Next-state decision: hold, release, or choose from idle.
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE: begin
                if (elig[0])        nxt_st = ST_G1;
                else if (elig[1])   nxt_st = ST_G2;
                else if (last_wait) nxt_st = ST_G3;
                else                nxt_st = ST_IDLE;
            end
            ST_G1:   nxt_st = req[0] ? ST_G1 : ST_IDLE;
            ST_G2:   nxt_st = req[1] ? ST_G2 : ST_IDLE;
            ST_G3:   nxt_st = req[2] ? ST_G3 : ST_IDLE;
            default: nxt_st = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/arb3_fair_flags.sv
// Module: "served while the last requester waits" marks.
// A mark is set when its requester wins a decision from idle while the last
// requester's request is high. Both marks clear when the last requester is
// chosen, when its request is low, or on reset.
// Assumes cur_st and nxt_st are the arbiter's present and next state.
module arb3_fair_flags
    import arb3_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            last_wait,
    input  arb_state_e      cur_st,
    input  arb_state_e      nxt_st,
    output logic [NHI-1:0]  served
);
    logic wipe;

    // Condition that ends the current waiting period.
    assign wipe = ~last_wait | (nxt_st == ST_G3);

    genvar fi;
    generate
        for (fi = 0; fi < NHI; fi++) begin : g_mark
            // Register for one requester's mark.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    served[fi] <= 1'b0;
                else if (wipe)
                    served[fi] <= 1'b0;
                else if (cur_st == ST_IDLE && nxt_st == serve_state(fi))
                    served[fi] <= 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/arb3_grant_dec.sv
// Module: Moore output decode, state to one-hot grant.
// Assumes grant state k+1 serves requester k. The idle state drives no grant.
module arb3_grant_dec
    import arb3_pkg::*;
(
    input  arb_state_e       cur_st,
    output logic [NREQ-1:0]  gnt
);
    genvar di;
    generate
        for (di = 0; di < NREQ; di++) begin : g_dec
            // One grant bit per matching state.
            assign gnt[di] = (cur_st == serve_state(di));
        end
    endgenerate
endmodule

// File: rtl/arb3_starve_guard.sv
// Module: three-requester fixed-priority arbiter with a starvation guard.
// Contains the state register, the next-state picker, the fairness marks and
// the grant decode. Assumes inputs change only after the rising edge and that
// the reset is synchronous and active low.
module arb3_starve_guard
    import arb3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req,
    output logic [NREQ-1:0]  gnt
);
    arb_state_e      cur_st;
    arb_state_e      nxt_st;
    logic [NHI-1:0]  served;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= ST_IDLE;
        else        cur_st <= nxt_st;
    end

    arb3_pick u_pick (
        .cur_st (cur_st),
        .req    (req),
        .served (served),
        .nxt_st (nxt_st)
    );

    arb3_fair_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_wait (req[NREQ-1]),
        .cur_st    (cur_st),
        .nxt_st    (nxt_st),
        .served    (served)
    );

    arb3_grant_dec u_dec (
        .cur_st (cur_st),
        .gnt    (gnt)
    );
endmodule

// File: rtl/arb3_starve_guard_chk.sv
// Module: assertion checker for arb3_starve_guard, attached with bind.
// Watches only the ports. It keeps its own record of which higher-priority
// requesters have been served during the current wait of requester 3.
module arb3_starve_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] req,
    input logic [2:0] gnt
);
    logic [2:0] gnt_q;
    logic       r3_q;
    logic       seen1, seen2;
    logic       rise1, rise2;

    assign rise1 = gnt[0] & ~gnt_q[0] & r3_q;
    assign rise2 = gnt[1] & ~gnt_q[1] & r3_q;

    // Record of grants handed out while requester 3 was waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= 3'b000;
            r3_q  <= 1'b0;
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else begin
            gnt_q <= gnt;
            r3_q  <= req[2];
            if (!req[2] || gnt[2]) begin
                seen1 <= 1'b0;
                seen2 <= 1'b0;
            end else begin
                if (rise1) seen1 <= 1'b1;
                if (rise2) seen2 <= 1'b1;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> gnt == 3'b000); // R1
    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2
    AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == 3'b000 && req == 3'b000) |=> gnt == 3'b000); // R3
    AST_PRIO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == 3'b000 && req[0] && !req[2]) |=> gnt == 3'b001); // R4
    AST_PRIO_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == 3'b000 && req == 3'b100) |=> gnt == 3'b100); // R4
    AST_HOLD_G1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[0] && req[0]) |=> gnt[0]); // R5
    AST_HOLD_G2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[1] && req[1]) |=> gnt[1]); // R5
    AST_HOLD_G3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[2] && req[2]) |=> gnt[2]); // R5
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) != 3'b000) |=> gnt == 3'b000); // R6
    AST_FAIR_ONCE_1: assert property (@(posedge clk) disable iff (!rst_n)
        rise1 |-> !seen1); // R7
    AST_FAIR_ONCE_2: assert property (@(posedge clk) disable iff (!rst_n)
        rise2 |-> !seen2); // R7
    AST_FAIR_FORCE3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == 3'b000 && req[2] && seen1 && seen2) |=> gnt == 3'b100); // R8
endmodule

bind arb3_starve_guard arb3_starve_guard_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
);

// File: tb/arb3_starve_guard_tb.sv
// Bench: scoreboard for arb3_starve_guard. The driver task applies inputs at the
// falling edge and queues the grant expected after the next rising edge. The
// monitor compares one queued item a quarter period after every rising edge.
module arb3_starve_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst_n;
    logic [2:0] req;
    logic [2:0] gnt;

    int checks   = 0;
    int failures = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    arb3_starve_guard u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: one cycle of stimulus plus its expected grant.
    task automatic step(input logic rn, input logic [2:0] r, input logic [2:0] e, input string tag);
        @(negedge clk);
        rst_n = rn;
        req   = r;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: pop and compare after each rising edge.
    initial begin
        logic [2:0] e;
        string      t;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (gnt !== e) begin
                    failures++;
                    $display("FAIL %s: gnt=%b expected=%b", t, gnt, e);
                end
                checks++;
                if (!$onehot0(gnt)) begin
                    failures++;
                    $display("FAIL R2: gnt=%b expected at most one bit set", gnt);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD*2000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Stimulus. req bits are {r3, r2, r1}.
    initial begin
        rst_n = 1'b0;
        req   = 3'b000;
        step(1'b0, 3'b111, 3'b000, "R1");  // reset wins over requests
        step(1'b0, 3'b000, 3'b000, "R1");
        step(1'b1, 3'b000, 3'b000, "R3");  // idle with no requests
        step(1'b1, 3'b000, 3'b000, "R3");
        // starvation run: r1 and r2 held except to release
        step(1'b1, 3'b111, 3'b001, "R4");  // r1 first, served while r3 waits
        step(1'b1, 3'b111, 3'b001, "R5");
        step(1'b1, 3'b110, 3'b000, "R6");
        step(1'b1, 3'b111, 3'b010, "R7");  // r1 skipped, r2 served
        step(1'b1, 3'b111, 3'b010, "R5");
        step(1'b1, 3'b101, 3'b000, "R6");
        step(1'b1, 3'b111, 3'b100, "R8");  // both served, r3 forced
        step(1'b1, 3'b111, 3'b100, "R5");
        step(1'b1, 3'b011, 3'b000, "R6");
        // plain priority
        step(1'b1, 3'b011, 3'b001, "R4");
        step(1'b1, 3'b010, 3'b000, "R6");
        step(1'b1, 3'b010, 3'b010, "R4");
        step(1'b1, 3'b000, 3'b000, "R6");
        step(1'b1, 3'b100, 3'b100, "R4");  // r3 alone
        step(1'b1, 3'b000, 3'b000, "R6");
        // r3 withdraws before service
        step(1'b1, 3'b111, 3'b001, "R4");
        step(1'b1, 3'b110, 3'b000, "R6");
        step(1'b1, 3'b001, 3'b001, "R9");  // r3 low: marks cleared
        step(1'b1, 3'b100, 3'b000, "R6");
        step(1'b1, 3'b111, 3'b001, "R9");  // fresh wait: r1 wins again
        step(1'b1, 3'b110, 3'b000, "R6");
        step(1'b1, 3'b111, 3'b010, "R7");
        step(1'b1, 3'b101, 3'b000, "R6");
        step(1'b1, 3'b111, 3'b100, "R8");
        // reset in the middle of a grant
        step(1'b0, 3'b111, 3'b000, "R1");
        step(1'b1, 3'b111, 3'b001, "R1");  // marks cleared by reset
        step(1'b1, 3'b000, 3'b000, "R6");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule